// File: doc/BRIEF.md
# Two-Wire Serial Slave with Paged Write Buffer

This block is a serial slave on a two-line bus with a clock line and an open-drain data line. Both lines are oversampled by the system clock. The block finds the bus start and stop conditions and takes in a device-select byte, most significant bit first. It answers on two device identities. One is a main identity supplied on an input port. The other is a fixed auxiliary identity, whose 8-bit write form is A0h. Each identity owns its own byte-wide register bank.

A write transaction carries a one-byte location pointer and then one or more data bytes. The data bytes go into an aligned page buffer. Only a stop condition commits the buffered bytes to the register bank. The commit starts a timed busy window, and the block is deaf to the bus until that window ends. A read transaction streams bytes from the pointer onward until the bus master declines a byte. A write-protect input rejects data bytes. The pointer byte is still taken while write protection is on, so protected parts can be read at random locations.

Top module: `twowire_page_slave`

## Requirements
- R1: A falling data line while the clock line is high is a start condition. From any state it discards the byte in progress and begins device-select reception. A rising data line while the clock is high is a stop condition and returns the block to idle.
- R2: The device-select byte is received most significant bit first, with bit 0 as the direction bit: 1 reads, 0 writes. Bits 7..1 equal to `main_dev_i` select bank 0. Bits 7..1 equal to 7'h50 select bank 1. When both match, bank 0 wins.
- R3: For every accepted byte the block holds the data line low for the whole ninth clock pulse and releases it after the next falling clock edge. The block changes its data drive only while the clock line is low.
- R4: A device-select byte matching neither identity gets no acknowledge. The block then leaves the data line released for every following byte until the next start condition.
- R5: In a write, the first byte after the device select sets the location pointer. Each data byte is stored at the pointer and acknowledged. Only the low 3 pointer bits then advance, wrapping inside the 8-byte page. The upper pointer bits stay fixed.
- R6: Buffered data bytes reach the bank only on a stop condition. A start condition before the stop discards them and leaves the bank unchanged.
- R7: A commit raises `busy_o` for exactly TW_CYCLES clock cycles. While `busy_o` is high the block ignores all bus activity, acknowledges nothing and never drives the data line.
- R8: While `wp_i` is high, write data bytes get no acknowledge and the bank keeps its contents. No busy window starts. The device-select byte and the pointer byte are still acknowledged.
- R9: A read returns the byte at the pointer, most significant bit first. The pointer then advances across the full address range, page boundaries included. After a byte the master declines, the block drives nothing.
- R10: The two banks hold separate contents at equal locations.
- R11: After reset the data line is released and `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples both bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level, as resolved on the wire |
| sda_oe_o | output | 1 | High pulls the data line low |
| main_dev_i | input | 7 | Seven-bit main device identity |
| wp_i | input | 1 | High rejects write data bytes |
| busy_o | output | 1 | High during the timed commit window |

## Verification
The assertions assume a well-formed bus. Each clock-line phase must last several system clocks longer than the synchronizer depth. The master moves the data line only while the clock is low, except when it creates a start or stop condition, so a line change during a driven bit always reaches the block after a falling edge it has already seen. The bench drives both lines on the falling system clock edge with ten-cycle phases. It resolves the data line as the master level AND-ed with the inverse of `sda_oe_o`. It starts a new transaction inside a busy window only when that transaction ends before the window closes.

// File: rtl/tw_pkg.sv
package tw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_MADDR,
      ST_WDATA,
      ST_ACK,
      ST_RDATA,
      ST_RACK
   } tw_state_e;

   typedef struct packed {
      logic start;
      logic stop;
      logic rise;
      logic fall;
      logic scl;
      logic sda;
   } tw_evt_t;

endpackage

// File: rtl/tw_line_sampler.sv
module tw_line_sampler
   import tw_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    scl_i,
   input  logic    sda_i,
   input  logic    hold_i,
   output tw_evt_t evt_o
);

   localparam int MSB = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tw_line_sampler: SYNC_STAGES must be at least 2");
   end

   logic [MSB:0] scl_sync, sda_sync;
   logic         scl_q, sda_q;
   logic         scl_s, sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sync <= '1;
         sda_sync <= '1;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         scl_sync <= {scl_sync[MSB-1:0], scl_i};
         sda_sync <= {sda_sync[MSB-1:0], sda_i};
         scl_q    <= scl_sync[MSB];
         sda_q    <= sda_sync[MSB];
      end
   end

   assign scl_s = scl_sync[MSB];
   assign sda_s = sda_sync[MSB];

   always_comb begin
      evt_o.scl   = scl_s;
      evt_o.sda   = sda_s;
      evt_o.start = ~hold_i & scl_s & scl_q & sda_q & ~sda_s;
      evt_o.stop  = ~hold_i & scl_s & scl_q & ~sda_q & sda_s;
      evt_o.rise  = ~hold_i & scl_s & ~scl_q;
      evt_o.fall  = ~hold_i & ~scl_s & scl_q;
   end

endmodule

// File: rtl/tw_page_buffer.sv
module tw_page_buffer #(
   parameter int PAGE_BYTES = 8,
   localparam int PAGE_W    = $clog2(PAGE_BYTES)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clear_i,
   input  logic                       wr_i,
   input  logic [PAGE_W-1:0]          idx_i,
   input  logic [7:0]                 data_i,
   output logic [PAGE_BYTES-1:0][7:0] data_o,
   output logic [PAGE_BYTES-1:0]      mask_o
);

   if (PAGE_BYTES < 2 || (1 << PAGE_W) != PAGE_BYTES) begin : g_bad_page
      $error("tw_page_buffer: PAGE_BYTES must be a power of two of at least 2");
   end

   for (genvar k = 0; k < PAGE_BYTES; k++) begin : g_slot
      logic [7:0] byte_q;
      logic       vld_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            byte_q <= '0;
            vld_q  <= 1'b0;
         end else if (clear_i) begin
            vld_q  <= 1'b0;
         end else if (wr_i && idx_i == PAGE_W'(k)) begin
            byte_q <= data_i;
            vld_q  <= 1'b1;
         end
      end

      assign data_o[k] = byte_q;
      assign mask_o[k] = vld_q;
   end

   // R6: a discard never collides with a store
   p_clear_wr_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(clear_i && wr_i));

endmodule

// File: rtl/tw_regfile.sv
module tw_regfile #(
   parameter int ADDR_W     = 8,
   parameter int PAGE_BYTES = 8,
   localparam int PAGE_W    = $clog2(PAGE_BYTES),
   localparam int DEPTH     = 1 << ADDR_W,
   localparam int BANKS     = 2
) (
   input  logic                       clk,
   input  logic                       commit_i,
   input  logic                       bank_i,
   input  logic [ADDR_W-PAGE_W-1:0]   base_i,
   input  logic [PAGE_BYTES-1:0][7:0] page_i,
   input  logic [PAGE_BYTES-1:0]      mask_i,
   input  logic                       rd_bank_i,
   input  logic [ADDR_W-1:0]          rd_addr_i,
   output logic [7:0]                 rd_data_o
);

   logic [7:0] mem [BANKS][DEPTH];

   always_ff @(posedge clk) begin
      if (commit_i) begin
         for (int k = 0; k < PAGE_BYTES; k++) begin
            if (mask_i[k]) begin
               mem[bank_i][{base_i, PAGE_W'(k)}] <= page_i[k];
            end
         end
      end
   end

   assign rd_data_o = mem[rd_bank_i][rd_addr_i];

endmodule

// File: rtl/tw_busy_timer.sv
module tw_busy_timer #(
   parameter int TW_CYCLES = 2000,
   localparam int CNT_W    = (TW_CYCLES > 2) ? $clog2(TW_CYCLES) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o
);

   if (TW_CYCLES < 1) begin : g_bad_tw
      $error("tw_busy_timer: TW_CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         cnt_q  <= '0;
      end else if (start_i) begin
         busy_o <= 1'b1;
         cnt_q  <= CNT_W'(TW_CYCLES - 1);
      end else if (busy_o) begin
         if (cnt_q == '0) busy_o <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   // R7: the window only opens on a commit request
   p_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

endmodule

// File: rtl/twowire_page_slave.sv
module twowire_page_slave
   import tw_pkg::*;
#(
   parameter int         ADDR_W      = 8,
   parameter int         PAGE_BYTES  = 8,
   parameter int         TW_CYCLES   = 2000,
   parameter int         SYNC_STAGES = 2,
   parameter logic [6:0] AUX_DEV     = 7'h50
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe_o,
   input  logic [6:0] main_dev_i,
   input  logic       wp_i,
   output logic       busy_o
);

   localparam int PAGE_W = $clog2(PAGE_BYTES);

   if (ADDR_W > 8 || ADDR_W <= PAGE_W) begin : g_bad_addr
      $error("twowire_page_slave: ADDR_W must exceed the page index width and fit in a byte");
   end

   tw_evt_t                   evt;
   tw_state_e                 st_q, nxt_q;
   logic [3:0]                bcnt_q;
   logic [7:0]                sh_q, tx_q;
   logic [ADDR_W-1:0]         ptr_q;
   logic                      bank_q;
   logic                      nack_q;
   logic                      oe_q;
   logic [7:0]                rd_data;
   logic [PAGE_BYTES-1:0][7:0] page_data;
   logic [PAGE_BYTES-1:0]     page_mask;
   logic                      byte_done, hit_main, hit_aux;
   logic                      buf_wr, buf_clear, commit;

   tw_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
      .clk    (clk),
      .rst_n  (rst_n),
      .scl_i  (scl_i),
      .sda_i  (sda_i),
      .hold_i (busy_o),
      .evt_o  (evt)
   );

   always_comb begin
      hit_main  = (sh_q[7:1] == main_dev_i);
      hit_aux   = (sh_q[7:1] == AUX_DEV);
      byte_done = evt.fall && (bcnt_q == 4'd8) &&
                  (st_q == ST_DEV || st_q == ST_MADDR || st_q == ST_WDATA);
      buf_wr    = byte_done && (st_q == ST_WDATA) && !wp_i;
      commit    = evt.stop && (|page_mask);
      buf_clear = evt.start || commit || (byte_done && st_q == ST_MADDR);
   end

   tw_page_buffer #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (buf_clear),
      .wr_i    (buf_wr),
      .idx_i   (ptr_q[PAGE_W-1:0]),
      .data_i  (sh_q),
      .data_o  (page_data),
      .mask_o  (page_mask)
   );

   tw_regfile #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_rf (
      .clk       (clk),
      .commit_i  (commit),
      .bank_i    (bank_q),
      .base_i    (ptr_q[ADDR_W-1:PAGE_W]),
      .page_i    (page_data),
      .mask_i    (page_mask),
      .rd_bank_i (bank_q),
      .rd_addr_i (ptr_q),
      .rd_data_o (rd_data)
   );

   tw_busy_timer #(.TW_CYCLES(TW_CYCLES)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (commit),
      .busy_o  (busy_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         nxt_q  <= ST_IDLE;
         bcnt_q <= '0;
         sh_q   <= '0;
         tx_q   <= '0;
         ptr_q  <= '0;
         bank_q <= 1'b0;
         nack_q <= 1'b0;
         oe_q   <= 1'b0;
      end else if (evt.start) begin
         st_q   <= ST_DEV;
         bcnt_q <= '0;
         oe_q   <= 1'b0;
      end else if (evt.stop) begin
         st_q   <= ST_IDLE;
         oe_q   <= 1'b0;
      end else begin
         unique case (st_q)
            ST_DEV, ST_MADDR, ST_WDATA: begin
               if (evt.rise && bcnt_q != 4'd8) begin
                  sh_q   <= {sh_q[6:0], evt.sda};
                  bcnt_q <= bcnt_q + 4'd1;
               end else if (byte_done) begin
                  bcnt_q <= '0;
                  if (st_q == ST_DEV) begin
                     if (hit_main || hit_aux) begin
                        bank_q <= !hit_main;
                        oe_q   <= 1'b1;
                        st_q   <= ST_ACK;
                        nxt_q  <= sh_q[0] ? ST_RDATA : ST_MADDR;
                     end else begin
                        st_q   <= ST_IDLE;
                     end
                  end else if (st_q == ST_MADDR) begin
                     ptr_q <= sh_q[ADDR_W-1:0];
                     oe_q  <= 1'b1;
                     st_q  <= ST_ACK;
                     nxt_q <= ST_WDATA;
                  end else if (wp_i) begin
                     st_q  <= ST_IDLE;
                  end else begin
                     ptr_q[PAGE_W-1:0] <= ptr_q[PAGE_W-1:0] + 1'b1;
                     oe_q  <= 1'b1;
                     st_q  <= ST_ACK;
                     nxt_q <= ST_WDATA;
                  end
               end
            end
            ST_ACK: begin
               if (evt.fall) begin
                  st_q <= nxt_q;
                  if (nxt_q == ST_RDATA) begin
                     tx_q   <= rd_data;
                     oe_q   <= ~rd_data[7];
                     ptr_q  <= ptr_q + 1'b1;
                     bcnt_q <= 4'd1;
                  end else begin
                     oe_q   <= 1'b0;
                  end
               end
            end
            ST_RDATA: begin
               if (evt.fall) begin
                  if (bcnt_q == 4'd8) begin
                     oe_q <= 1'b0;
                     st_q <= ST_RACK;
                  end else begin
                     oe_q   <= ~tx_q[6];
                     tx_q   <= {tx_q[6:0], 1'b0};
                     bcnt_q <= bcnt_q + 4'd1;
                  end
               end
            end
            ST_RACK: begin
               if (evt.rise) begin
                  nack_q <= evt.sda;
               end else if (evt.fall) begin
                  if (nack_q) begin
                     st_q   <= ST_IDLE;
                  end else begin
                     tx_q   <= rd_data;
                     oe_q   <= ~rd_data[7];
                     ptr_q  <= ptr_q + 1'b1;
                     bcnt_q <= 4'd1;
                     st_q   <= ST_RDATA;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_oe_o = oe_q;

   // R3: drive changes land while the sampled clock line is low
   p_sda_change_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(oe_q) && !$past(evt.start || evt.stop)) |-> !evt.scl);

   // R7: no drive at all inside the busy window
   p_no_drive_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !sda_oe_o);

   // R4: an idle slave keeps the line released
   p_idle_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE) |-> !oe_q);

   // R5: a stored byte never moves the page base
   p_page_upper_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      buf_wr |=> $stable(ptr_q[ADDR_W-1:PAGE_W]));

endmodule

// File: tb/sim_twowire_page_slave.sv
module sim_twowire_page_slave;

   localparam int TW = 800;
   localparam int PH = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [6:0] main_dev = 7'h51;
   logic       wp = 1'b0;
   logic       sda_oe, busy;
   logic       sda_line;

   int n_chk = 0;
   int n_err = 0;
   int busy_run = 0;
   int busy_last = 0;

   logic [7:0] model [2][256];
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic [7:0] act_q[$];

   always #5 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   twowire_page_slave #(.TW_CYCLES(TW)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_m),
      .sda_i      (sda_line),
      .sda_oe_o   (sda_oe),
      .main_dev_i (main_dev),
      .wp_i       (wp),
      .busy_o     (busy)
   );

   always @(posedge clk) begin
      if (busy) busy_run <= busy_run + 1;
      else begin
         if (busy_run != 0) busy_last <= busy_run;
         busy_run <= 0;
      end
   end

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         while (act_q.size() > 0) begin
            logic [7:0] a;
            a = act_q.pop_front();
            if (exp_q.size() == 0) check("R9 unexpected read byte", 32'(a), 32'hFFFF);
            else check(tag_q.pop_front(), 32'(a), 32'(exp_q.pop_front()));
         end
      end
   end

   task automatic wait_ph();
      repeat (PH) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wait_ph();
      scl_m = 1'b1; wait_ph();
      sda_m = 1'b0; wait_ph();
      scl_m = 1'b0; wait_ph();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wait_ph();
      scl_m = 1'b1; wait_ph();
      sda_m = 1'b1; wait_ph();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wait_ph();
         scl_m = 1'b1; wait_ph(); wait_ph();
         scl_m = 1'b0; wait_ph();
      end
      sda_m = 1'b1; wait_ph();
      scl_m = 1'b1; wait_ph();
      ack = ~sda_line; wait_ph();
      scl_m = 1'b0; wait_ph();
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1'b1; wait_ph();
         scl_m = 1'b1; wait_ph();
         b[i] = sda_line; wait_ph();
         scl_m = 1'b0; wait_ph();
      end
      sda_m = give_ack ? 1'b0 : 1'b1; wait_ph();
      scl_m = 1'b1; wait_ph(); wait_ph();
      scl_m = 1'b0; wait_ph();
      sda_m = 1'b1;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   // driver: write transaction, model update on accepted data
   task automatic write_txn(input logic [6:0] dev, input logic bank, input logic [7:0] addr,
                            input logic [7:0] d[$], input logic data_ack);
      logic ack;
      logic [7:0] p;
      bus_start();
      send_byte({dev, 1'b0}, ack); check("R2 write select ack", 32'(ack), 32'd1);
      send_byte(addr, ack);        check("R5 pointer byte ack", 32'(ack), 32'd1);
      p = addr;
      foreach (d[i]) begin
         send_byte(d[i], ack);
         check(data_ack ? "R3 data ack" : "R8 protected data nack", 32'(ack), 32'(data_ack));
         if (data_ack) model[bank][p] = d[i];
         p = {p[7:3], p[2:0] + 3'd1};
         if (!data_ack) break;
      end
      bus_stop();
   endtask

   // driver: random read; expected bytes go to the scoreboard queue
   task automatic read_txn(input logic [6:0] dev, input logic bank, input logic [7:0] addr,
                           input int n, input string tag);
      logic ack;
      logic [7:0] b;
      bus_start();
      send_byte({dev, 1'b0}, ack); check("R2 read setup ack", 32'(ack), 32'd1);
      send_byte(addr, ack);        check("R5 read pointer ack", 32'(ack), 32'd1);
      bus_start();
      send_byte({dev, 1'b1}, ack); check("R1 repeated start read select ack", 32'(ack), 32'd1);
      for (int i = 0; i < n; i++) begin
         exp_q.push_back(model[bank][8'(addr + i)]);
         tag_q.push_back(tag);
         recv_byte(i < n - 1, b);
         act_q.push_back(b);
      end
      check("R9 released after master nack", 32'(sda_oe), 32'd0);
      bus_stop();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic ack;
      logic [7:0] d[$];
      repeat (5) @(negedge clk);
      check("R11 reset oe", 32'(sda_oe), 32'd0);
      check("R11 reset busy", 32'(busy), 32'd0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // full page in bank 0 at 08h, then 10h
      d = {8'h10, 8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16, 8'h17};
      write_txn(7'h51, 1'b0, 8'h08, d, 1'b1);
      check("R7 busy after commit", 32'(busy), 32'd1);
      wait_idle();
      check("R7 busy window length", 32'(busy_last), 32'(TW));
      d = {8'h80, 8'h81, 8'h82, 8'h83, 8'h84, 8'h85, 8'h86, 8'h87};
      write_txn(7'h51, 1'b0, 8'h10, d, 1'b1);
      wait_idle();
      read_txn(7'h51, 1'b0, 8'h08, 10, "R9 sequential read across page");

      // wrap inside the page
      d = {8'hA1, 8'hB2, 8'hC3};
      write_txn(7'h51, 1'b0, 8'h0E, d, 1'b1);
      wait_idle();
      read_txn(7'h51, 1'b0, 8'h08, 8, "R5 page wrap contents");

      // auxiliary bank
      d = {8'h5A, 8'h5B, 8'h5C, 8'h5D, 8'h5E, 8'h5F, 8'h60, 8'h61};
      write_txn(7'h50, 1'b1, 8'h08, d, 1'b1);
      wait_idle();
      read_txn(7'h50, 1'b1, 8'h08, 8, "R10 aux bank contents");
      read_txn(7'h51, 1'b0, 8'h08, 2, "R10 main bank untouched");

      // lockout during busy window
      d = {8'h77};
      write_txn(7'h51, 1'b0, 8'h20, d, 1'b1);
      check("R7 busy raised", 32'(busy), 32'd1);
      bus_start();
      send_byte({7'h51, 1'b1}, ack);
      check("R7 no ack while busy", 32'(ack), 32'd0);
      check("R7 busy still high", 32'(busy), 32'd1);
      bus_stop();
      wait_idle();
      read_txn(7'h51, 1'b0, 8'h20, 1, "R7 committed byte");

      // mismatching device select
      bus_start();
      send_byte({7'h33, 1'b0}, ack);
      check("R4 mismatch nack", 32'(ack), 32'd0);
      send_byte(8'h00, ack);
      check("R4 later byte ignored", 32'(ack), 32'd0);
      bus_stop();
      repeat (10) @(negedge clk);
      check("R4 no busy after mismatch", 32'(busy), 32'd0);

      // repeated start discards buffered bytes
      bus_start();
      send_byte({7'h51, 1'b0}, ack);
      send_byte(8'h20, ack);
      send_byte(8'h99, ack);
      check("R6 buffered byte ack", 32'(ack), 32'd1);
      bus_start();
      bus_stop();
      repeat (10) @(negedge clk);
      check("R6 no commit after restart", 32'(busy), 32'd0);
      read_txn(7'h51, 1'b0, 8'h20, 1, "R6 bank unchanged after restart");

      // write protection
      wp = 1'b1;
      d = {8'h44};
      write_txn(7'h51, 1'b0, 8'h20, d, 1'b0);
      repeat (10) @(negedge clk);
      check("R8 no busy when protected", 32'(busy), 32'd0);
      wp = 1'b0;
      read_txn(7'h51, 1'b0, 8'h20, 1, "R8 bank unchanged when protected");

      // main identity equal to auxiliary: bank 0 wins
      main_dev = 7'h50;
      read_txn(7'h50, 1'b0, 8'h08, 2, "R2 main wins on equal identity");
      main_dev = 7'h51;

      repeat (20) @(negedge clk);
      check("R9 scoreboard drained", 32'(exp_q.size()), 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule